// File: doc/BRIEF.md
# Serial DAC Input Front End

This block is the digital front end of a 12-bit voltage-output converter with a serial input. A host shifts a 16-bit word in over three wires: a serial clock, a data line and an active-low frame strobe. A separate active-low load strobe then moves the low 12 bits of that word into a DAC latch. Only the latch drives the converter code bus, so a new word can be shifted in while the output holds its old value. Because the load strobe can be wired to many devices at once, they can all change at the same moment.

Two framing modes are available. In standalone mode a bit counter admits exactly 16 falling serial-clock edges per frame and then locks out the clock until the next frame. This lets a free-running clock be used as well as a burst clock. In chained mode the counter is bypassed. The register shifts on every falling edge while the frame is low, and its top bit is presented on a serial output so that devices can be cascaded. Range and coding inputs choose natural binary (unipolar), offset binary or two's complement (bipolar). A clear input forces the 0 V code of the range, or negative full scale for offset binary.

The serial pins are assumed to be already synchronous to the system clock `clk`. They are sampled once per cycle, and their edges are found by comparing each sample with the previous one. The code bus always carries the internal code: natural binary for unipolar, and offset binary for both bipolar codings.

Top module: `serdac_front`

## Requirements
- R1: After a synchronous reset (rst_n low at a clk edge) sdo is 0.
- R2: While sync_n is low, each falling sclk edge shifts sdin into the 16-bit register MSB first. A later load puts bits 11..0 of the word on dac_code, and bits 15..12 have no effect on it.
- R3: With chain_en = 0, only the first 16 falling sclk edges of a frame are shifted in. Any later edges before sync_n rises leave the register unchanged.
- R4: Falling sclk edges while sync_n is high shift nothing.
- R5: Taking sync_n high and then low again re-arms the 16-edge counter for a new frame.
- R6: With chain_en = 1, every falling sclk edge while sync_n is low shifts, so the register holds the last 16 bits received.
- R7: sdo changes only in the cycle after a rising sclk edge, and it then shows the register MSB. In chained mode it therefore repeats the previous word MSB first during the next frame.
- R8: dac_code changes only after a falling edge on ldac_n, or through clear or reset. Shifting alone never changes it.
- R9: With bipolar = 1 and twos = 1, the loaded code is the data field with its MSB inverted. In all other cases the loaded code equals the data field.
- R10: While clr_n is low, dac_code is the clear code of the present mode, and it follows mode changes at once. The clear code is 0x000 for unipolar, 0x800 for bipolar two's complement, and 0x000 for bipolar offset binary. A load during clear is ignored, and the clear code stays after clr_n rises.
- R11: The reset value of dac_code is the clear code of the mode present during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data in, MSB first |
| sync_n | input | 1 | Active-low frame strobe |
| ldac_n | input | 1 | Active-low load strobe; a falling edge copies the data field to the latch |
| clr_n | input | 1 | Active-low clear of the output code |
| chain_en | input | 1 | 1 selects chained mode (no edge gating), 0 selects standalone mode |
| bipolar | input | 1 | 1 selects the bipolar range, 0 the unipolar range |
| twos | input | 1 | In the bipolar range, 1 selects two's complement input, 0 offset binary |
| sdo | output | 1 | Serial data out: register MSB, updated after a rising sclk edge |
| dac_code | output | 12 | Code held by the DAC latch |

## Verification
On every cycle the assertions check three things. The output code moves only after a load edge or a clear. The clear code always matches the range and coding inputs. The serial output changes only after a rising serial-clock edge. The values that reach the latch are shown only by the bench's scenarios: MSB-first assembly, the 16-edge lockout, re-arming on a new frame, bits taken in chained mode, two's-complement conversion, and the serial output replaying the previous word.

// File: rtl/serdac_pkg.sv
// Shared sizes and the code mapping for the serial DAC front end.
// Assumes a 16-bit frame whose low CODE_W bits form the converter code.
package serdac_pkg;
    localparam int WORD_W = 16;
    localparam int CODE_W = 12;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    // Turn a data field into the internal code (two's complement gets its MSB flipped)
    function automatic logic [CODE_W-1:0] map_code(input logic [CODE_W-1:0] d,
                                                   input logic bip, input logic tc);
        logic [CODE_W-1:0] r;
        r = d;
        if (bip && tc) r[CODE_W-1] = ~d[CODE_W-1];
        return r;
    endfunction

    // Code forced by clear: 0 V, or negative full scale for offset binary
    function automatic logic [CODE_W-1:0] clear_code(input logic bip, input logic tc);
        logic [CODE_W-1:0] r;
        r = '0;
        if (bip && tc) r[CODE_W-1] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/serdac_edge.sv
// Edge finder for a vector of pins that are already synchronous to clk.
// Keeps one previous sample per bit; IDLE sets the remembered value after reset.
module serdac_edge #(
    parameter int N = 2,
    parameter logic [N-1:0] IDLE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    // Remember last cycle's pin levels
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= sig;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = ~prev_q[i] &  sig[i];
        assign fall[i] =  prev_q[i] & ~sig[i];
    end
endmodule

// File: rtl/serdac_shifter.sv
// Input shift register with the per-frame edge counter and the serial output.
// Standalone mode gates the register to WORD_W edges per frame; chained mode does not gate.
module serdac_shifter
    import serdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall,
    input  logic              sclk_rise,
    input  logic              sdin,
    input  logic              sync_n,
    input  logic              chain_en,
    output logic [WORD_W-1:0] word,
    output logic              sdo
);
    logic [CNT_W-1:0] cnt_q;
    logic             gate_open;
    logic             take;

    assign gate_open = chain_en || (cnt_q < CNT_W'(WORD_W));
    assign take      = sclk_fall && !sync_n && gate_open;

    // Count accepted edges; the counter is held at zero while the frame is idle
    always_ff @(posedge clk) begin
        if (!rst_n || sync_n)      cnt_q <= '0;
        else if (take && !chain_en) cnt_q <= cnt_q + 1'b1;
    end

    // Shift the data MSB first
    always_ff @(posedge clk) begin
        if (!rst_n)    word <= '0;
        else if (take) word <= {word[WORD_W-2:0], sdin};
    end

    // Present the register MSB after each rising serial clock edge
    always_ff @(posedge clk) begin
        if (!rst_n)         sdo <= 1'b0;
        else if (sclk_rise) sdo <= word[WORD_W-1];
    end
endmodule

// File: rtl/serdac_latch.sv
// DAC latch: loads the mapped data field on a load edge and applies the clear code.
// Clear overrides the output without waiting for a clock; the latch follows it on the next edge.
module serdac_latch
    import serdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clr_n,
    input  logic              bipolar,
    input  logic              twos,
    input  logic [CODE_W-1:0] field,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] latch_q;
    logic [CODE_W-1:0] clr_val;

    assign clr_val = clear_code(bipolar, twos);

    // Hold the code; reset and clear both load the clear value
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) latch_q <= clr_val;
        else if (load)        latch_q <= map_code(field, bipolar, twos);
    end

    // Clear takes effect on the bus at once
    always_comb begin
        code = clr_n ? latch_q : clr_val;
    end
endmodule

// File: rtl/serdac_front.sv
// Top level of the serial DAC front end: edge finding, shifting and the latch.
// Assumes sclk, sdin, sync_n, ldac_n and clr_n are synchronous to clk and change slower than it.
module serdac_front
    import serdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              sync_n,
    input  logic              ldac_n,
    input  logic              clr_n,
    input  logic              chain_en,
    input  logic              bipolar,
    input  logic              twos,
    output logic              sdo,
    output logic [CODE_W-1:0] dac_code
);
    logic [1:0]        rise;
    logic [1:0]        fall;
    logic [WORD_W-1:0] word;

    serdac_edge #(.N(2), .IDLE(2'b11)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  ({ldac_n, sclk}),
        .rise (rise),
        .fall (fall)
    );

    serdac_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_fall(fall[0]),
        .sclk_rise(rise[0]),
        .sdin     (sdin),
        .sync_n   (sync_n),
        .chain_en (chain_en),
        .word     (word),
        .sdo      (sdo)
    );

    serdac_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (fall[1]),
        .clr_n  (clr_n),
        .bipolar(bipolar),
        .twos   (twos),
        .field  (word[CODE_W-1:0]),
        .code   (dac_code)
    );
endmodule

// File: rtl/serdac_front_chk.sv
// Port-level checker for serdac_front, bound to every instance of it.
module serdac_front_chk
    import serdac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              ldac_n,
    input logic              clr_n,
    input logic              bipolar,
    input logic              twos,
    input logic              sdo,
    input logic [CODE_W-1:0] dac_code
);
    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && clr_n && $past(clr_n) && !($past(ldac_n, 2) && !$past(ldac_n)))
        |-> $stable(dac_code));

    // R10
    clear_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_code == ((bipolar && twos) ? 12'h800 : 12'h000)));

    // R7
    sdo_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(sdo)) |-> ($past(sclk) && !$past(sclk, 2)));

    // R1
    sdo_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sdo == 1'b0));
endmodule

bind serdac_front serdac_front_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk),
    .ldac_n  (ldac_n),
    .clr_n   (clr_n),
    .bipolar (bipolar),
    .twos    (twos),
    .sdo     (sdo),
    .dac_code(dac_code)
);

// File: tb/serdac_front_test.sv
module serdac_front_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        sdin = 1'b0;
    logic        sync_n = 1'b1;
    logic        ldac_n = 1'b1;
    logic        clr_n = 1'b1;
    logic        chain_en = 1'b0;
    logic        bipolar = 1'b0;
    logic        twos = 1'b0;
    logic        sdo;
    logic [11:0] dac_code;

    int checks = 0;
    int errors = 0;
    logic [11:0] exp_q[$];
    string       tag_q[$];
    event        load_ev;
    logic        last_sdo;

    serdac_front uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .sync_n(sync_n),
        .ldac_n(ldac_n), .clr_n(clr_n), .chain_en(chain_en), .bipolar(bipolar),
        .twos(twos), .sdo(sdo), .dac_code(dac_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit: sample sdo in the high phase, then the falling edge shifts
    task automatic send_bit(input logic b);
        sdin = b;
        sclk = 1'b1;
        wait_cyc(3);
        last_sdo = sdo;
        sclk = 1'b0;
        wait_cyc(3);
    endtask

    task automatic send_frame(input logic [31:0] w, input int nbits);
        sync_n = 1'b0;
        wait_cyc(2);
        for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
        sclk = 1'b1;
        wait_cyc(2);
        sync_n = 1'b1;
        wait_cyc(2);
    endtask

    // Driver: push the expected code, pulse the load strobe, wake the monitor
    task automatic load(input logic [11:0] expv, input string req);
        exp_q.push_back(expv);
        tag_q.push_back(req);
        ldac_n = 1'b0;
        wait_cyc(3);
        ldac_n = 1'b1;
        wait_cyc(2);
        -> load_ev;
        wait_cyc(1);
    endtask

    // Monitor: compare the latched code with the scoreboard head
    initial begin
        forever begin
            @(load_ev);
            if (exp_q.size() > 0) check(tag_q.pop_front(), {4'h0, dac_code}, {4'h0, exp_q.pop_front()});
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 sdo after reset", {15'h0, sdo}, 16'h0);
        check("R11 unipolar reset code", {4'h0, dac_code}, 16'h000);

        // R2: upper nibble set, low 12 bits reach the latch
        send_frame(32'h0000FABC, 16);
        check("R8 no change before load", {4'h0, dac_code}, 16'h000);
        load(12'hABC, "R2 msb first low field");

        // R3: 20 edges, only the first 16 taken
        send_frame(32'h0001234F, 20);
        load(12'h234, "R3 gating after 16 edges");

        // R5: new frame re-arms the counter
        send_frame(32'h00000567, 16);
        check("R8 shift leaves code", {4'h0, dac_code}, 16'h234);
        load(12'h567, "R5 rearm on new frame");

        // R4: clock edges with frame high are ignored
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        sclk = 1'b1;
        wait_cyc(2);
        load(12'h567, "R4 edges outside frame");

        // R9: bipolar codings
        bipolar = 1'b1;
        twos = 1'b1;
        send_frame(32'h00000000, 16);
        load(12'h800, "R9 twos zero");
        send_frame(32'h000007FF, 16);
        load(12'hFFF, "R9 twos max positive");
        send_frame(32'h00000800, 16);
        load(12'h000, "R9 twos max negative");
        twos = 1'b0;
        send_frame(32'h00000800, 16);
        load(12'h800, "R9 offset binary passes");

        // R10: clear codes per mode
        clr_n = 1'b0;
        wait_cyc(1);
        check("R10 clear offset binary", {4'h0, dac_code}, 16'h000);
        twos = 1'b1;
        wait_cyc(1);
        check("R10 clear twos", {4'h0, dac_code}, 16'h800);
        bipolar = 1'b0;
        wait_cyc(1);
        check("R10 clear unipolar", {4'h0, dac_code}, 16'h000);
        send_frame(32'h00000ABC, 16);
        ldac_n = 1'b0;
        wait_cyc(3);
        ldac_n = 1'b1;
        wait_cyc(2);
        check("R10 load ignored in clear", {4'h0, dac_code}, 16'h000);
        clr_n = 1'b1;
        wait_cyc(3);
        check("R10 code kept after clear", {4'h0, dac_code}, 16'h000);
        twos = 1'b0;

        // R6: chained mode takes every edge
        chain_en = 1'b1;
        send_frame(32'h000ABCDE, 20);
        load(12'hCDE, "R6 chained last 16 bits");

        // R7: sdo replays the previous word MSB first
        sync_n = 1'b0;
        wait_cyc(2);
        for (int i = 15; i >= 0; i--) begin
            logic [15:0] nxt;
            nxt = 16'h5A3C;
            send_bit(nxt[i]);
            check("R7 sdo replay", {15'h0, last_sdo}, {15'h0, 1'(16'hBCDE >> i)});
        end
        sclk = 1'b1;
        wait_cyc(2);
        sync_n = 1'b1;
        wait_cyc(2);
        load(12'hA3C, "R6 chained second word");
        chain_en = 1'b0;

        // R11: reset in bipolar two's complement gives its clear code
        bipolar = 1'b1;
        twos = 1'b1;
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R11 bipolar twos reset code", {4'h0, dac_code}, 16'h800);
        check("R1 sdo after second reset", {15'h0, sdo}, 16'h0);

        wait_cyc(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule